// File: doc/BRIEF.md
# Constant On-Time Buck Cycle Sequencer

This block sequences the switching cycle of one synchronous buck phase that runs with constant on-time, valley-triggered control. Each clock it samples a set of comparator flags: the output has sagged to its regulation point, the valley current is above the positive limit, the inductor current has crossed zero, the negative current limit has tripped, and an external charge pump has enough voltage. From these flags it drives a high-side and a low-side gate enable with a guard interval between them. The on-time length arrives as a cycle count from a block outside that derives it from input and output voltage.

Three light-load behaviours are selectable. In forced PWM the low-side switch conducts for the whole off period. In pulse skip the low-side switch opens at the zero crossing and both switches rest until the output sags again. In the quiet (no-audible) mode an idle timeout started at each on-time turns the low-side switch back on to pull the output down, so the switching rate cannot fall into the audible band. A low charge-pump flag makes pulse skip behave as quiet mode so the pump keeps being refreshed. A forced-discharge input lets a fault supervisor hold the low-side switch on.

All times (minimum on-time, minimum off-time, guard interval, idle timeout) are counted in clock cycles.

Top module: `cot_phase_seq`

## Requirements
- R1: A new switching cycle is decided at a clock edge only when, at that same edge, out_low=1, valley_over=0, force_dis=0, en=1 and the minimum off-time has run out; hs_en then rises DEAD+1 sampling cycles after those inputs are applied.
- R2: After hs_en falls, ls_en stays low for at least DEAD cycles; after ls_en falls, hs_en stays low for at least DEAD cycles.
- R3: hs_en and ls_en are never high in the same cycle.
- R4: Each on-time lasts max(ton_cycles, MIN_ON) cycles, with ton_cycles taken at the edge the on-time begins (unless en drops first).
- R5: In pulse skip (mode_sel=1, pump_ok=1), zero_cross=1 during the low-side period drops ls_en in the next cycle, and both enables stay low until the next cycle is decided.
- R6: In forced PWM (mode_sel=0), zero_cross has no effect: ls_en stays high through the whole off period until the next cycle is decided.
- R7: In quiet mode (mode_sel=2 or 3), when both switches are resting, ls_en rises exactly IDLE_CYC cycles after the most recent hs_en rise; once that timeout has passed, zero_cross no longer removes ls_en, which stays high until the next cycle is decided.
- R8: With pump_ok=0, pulse skip mode (mode_sel=1) behaves exactly as quiet mode of R7.
- R9: While neg_limit=1, ls_en is low in the same cycle.
- R10: During reset and while en=0, both enables are low, with hs_en and ls_en dropping in the same cycle that en falls.
- R11: While force_dis=1, no new cycle is decided, zero_cross is ignored, and a resting phase turns ls_en on once the guard interval has passed; ls_en then stays high (subject to R9).
- R12: Between two on-times, hs_en stays low for at least MIN_OFF+DEAD cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Phase enable; low forces both gate enables off |
| mode_sel | input | 2 | 0 forced PWM, 1 pulse skip, 2 or 3 quiet skip |
| ton_cycles | input | CNT_W | Requested on-time in clock cycles |
| out_low | input | 1 | Output is at or below regulation |
| valley_over | input | 1 | Valley current is above the positive limit |
| zero_cross | input | 1 | Inductor current has reached zero |
| neg_limit | input | 1 | Negative current limit tripped |
| pump_ok | input | 1 | Charge-pump feedback is high enough; low forces quiet behaviour |
| force_dis | input | 1 | Supervisor request to hold the low-side switch on |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The hardest state to reach is the quiet-mode timeout: the phase must finish an on-time, see a zero crossing that parks both switches, and then sit idle with the output above regulation until the timeout measured from the last on-time start fires. The stimulus gets there by letting one cycle start, immediately raising the output and holding zero_cross high, then counting cycles from the high-side rise to the exact low-side rise; it repeats this with pulse skip selected and the pump flag low. A randomized run with a fixed seed then mixes flag patterns, mode changes, enable drops and short limit pulses while a monitor checks guard intervals, on-time lengths, start qualification and overlap at every edge of the enables.

// File: rtl/cot_pkg.sv
package cot_pkg;

  typedef enum logic [1:0] {
    MD_FORCED = 2'd0,
    MD_SKIP   = 2'd1,
    MD_QUIET  = 2'd2,
    MD_QUIET2 = 2'd3
  } run_mode_t;

  typedef enum logic [2:0] {
    ST_REST = 3'd0,  // both switches off, waiting
    ST_PREP = 3'd1,  // guard interval before the high side
    ST_HIGH = 3'd2,  // on-time
    ST_GAP  = 3'd3,  // guard interval after the high side
    ST_LOW  = 3'd4   // low side conducting
  } seq_state_t;

endpackage

// File: rtl/cot_span_timer.sv
module cot_span_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && ($past(cnt_q) == '0)) |-> (cnt_q == '0)); // R12

endmodule

// File: rtl/cot_seq_fsm.sv
module cot_seq_fsm
  import cot_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int MIN_ON = 4,
  parameter int DEAD   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] ton_cycles,
  input  logic             out_low,
  input  logic             valley_over,
  input  logic             zero_cross,
  input  logic             pump_ok,
  input  logic             force_dis,
  input  logic             ph_done,
  input  logic             off_done,
  input  logic             idle_done,
  output logic             ph_load,
  output logic [CNT_W-1:0] ph_val,
  output logic             off_load,
  output logic             idle_load,
  output logic             hs_raw,
  output logic             ls_raw
);

  localparam logic [CNT_W-1:0] MIN_ON_V  = CNT_W'(MIN_ON);
  localparam logic [CNT_W-1:0] GUARD_V   = CNT_W'(DEAD - 1);

  seq_state_t st_q;
  seq_state_t st_d;
  run_mode_t  mode;
  logic       start_ok;
  logic       quiet_eff;
  logic       cut_ok;
  logic       wake_ok;
  logic [CNT_W-1:0] on_len;

  always_comb begin
    mode      = run_mode_t'(mode_sel);
    quiet_eff = (mode == MD_QUIET) || (mode == MD_QUIET2) ||
                ((mode == MD_SKIP) && !pump_ok);
    start_ok  = out_low && !valley_over && off_done && !force_dis;
    cut_ok    = (mode != MD_FORCED) && !force_dis && !(quiet_eff && idle_done);
    wake_ok   = ph_done && (force_dis || (quiet_eff && idle_done));
    on_len    = (ton_cycles < MIN_ON_V) ? MIN_ON_V : ton_cycles;
  end

  // next-state process
  always_comb begin
    st_d      = st_q;
    ph_load   = 1'b0;
    ph_val    = GUARD_V;
    off_load  = 1'b0;
    idle_load = !en;
    if (!en) begin
      st_d     = ST_REST;
      ph_load  = 1'b1;
      off_load = 1'b1;
    end else begin
      unique case (st_q)
        ST_REST: begin
          if (start_ok) begin
            st_d    = ST_PREP;
            ph_load = 1'b1;
          end else if (wake_ok) begin
            st_d = ST_LOW;
          end
        end
        ST_PREP: begin
          if (ph_done) begin
            st_d      = ST_HIGH;
            ph_load   = 1'b1;
            ph_val    = on_len - 1'b1;
            idle_load = 1'b1;
          end
        end
        ST_HIGH: begin
          if (ph_done) begin
            st_d     = ST_GAP;
            ph_load  = 1'b1;
            off_load = 1'b1;
          end
        end
        ST_GAP: begin
          if (ph_done) begin
            st_d = ST_LOW;
          end
        end
        ST_LOW: begin
          if (start_ok) begin
            st_d    = ST_PREP;
            ph_load = 1'b1;
          end else if (zero_cross && cut_ok) begin
            st_d = ST_REST;
          end
        end
        default: st_d = ST_REST;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_REST;
    end else begin
      st_q <= st_d;
    end
  end

  assign hs_raw = (st_q == ST_HIGH);
  assign ls_raw = (st_q == ST_LOW);

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_PREP) && ($past(st_q) != ST_PREP)) |->
      $past(out_low && !valley_over && off_done && !force_dis && en)); // R1

  AST_NO_HIGH_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW) |-> ($past(st_q) != ST_HIGH)); // R2

  AST_HIGH_AFTER_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HIGH) |-> ($past(st_q) inside {ST_HIGH, ST_PREP})); // R2

  AST_FORCED_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_REST) && ($past(st_q) == ST_LOW) && $past(en)) |->
      ($past(mode_sel) != 2'd0)); // R6

endmodule

// File: rtl/cot_phase_seq.sv
module cot_phase_seq #(
  parameter int CNT_W    = 10,
  parameter int MIN_ON   = 4,
  parameter int MIN_OFF  = 6,
  parameter int DEAD     = 2,
  parameter int IDLE_CYC = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] ton_cycles,
  input  logic             out_low,
  input  logic             valley_over,
  input  logic             zero_cross,
  input  logic             neg_limit,
  input  logic             pump_ok,
  input  logic             force_dis,
  output logic             hs_en,
  output logic             ls_en
);

  localparam int OFF_W  = $clog2(MIN_OFF + 1);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam logic [OFF_W-1:0]  OFF_LOAD  = OFF_W'(MIN_OFF - 1);
  localparam logic [IDLE_W-1:0] IDLE_LOAD = IDLE_W'(IDLE_CYC - 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             ph_load;
  logic [CNT_W-1:0] ph_val;
  logic             ph_done;
  logic             off_load;
  logic             off_done;
  logic             idle_load;
  logic             idle_done;
  logic             hs_raw;
  logic             ls_raw;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  cot_seq_fsm #(
    .CNT_W  (CNT_W),
    .MIN_ON (MIN_ON),
    .DEAD   (DEAD)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .en          (en),
    .mode_sel    (mode_sel),
    .ton_cycles  (ton_cycles),
    .out_low     (out_low),
    .valley_over (valley_over),
    .zero_cross  (zero_cross),
    .pump_ok     (pump_ok),
    .force_dis   (force_dis),
    .ph_done     (ph_done),
    .off_done    (off_done),
    .idle_done   (idle_done),
    .ph_load     (ph_load),
    .ph_val      (ph_val),
    .off_load    (off_load),
    .idle_load   (idle_load),
    .hs_raw      (hs_raw),
    .ls_raw      (ls_raw)
  );

  // shared timer for on-time and both guard intervals
  cot_span_timer #(.W(CNT_W)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (ph_load),
    .load_val (ph_val),
    .done     (ph_done)
  );

  cot_span_timer #(.W(OFF_W)) u_offmin_tmr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (off_load),
    .load_val (OFF_LOAD),
    .done     (off_done)
  );

  cot_span_timer #(.W(IDLE_W)) u_idle_tmr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (idle_load),
    .load_val (IDLE_LOAD),
    .done     (idle_done)
  );

  assign hs_en = en && rst_n_int && hs_raw;
  assign ls_en = en && rst_n_int && ls_raw && !neg_limit;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(hs_en && ls_en)); // R3

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    !en |=> (!hs_en && !ls_en)); // R10

  AST_LOW_AFTER_GUARD: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($past(hs_en) && !hs_en) |-> !ls_en); // R2

endmodule

// File: tb/cot_phase_seq_bench.sv
module cot_phase_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T_CNT_W    = 10;
  localparam int T_MIN_ON   = 4;
  localparam int T_MIN_OFF  = 6;
  localparam int T_DEAD     = 2;
  localparam int T_IDLE     = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [T_CNT_W-1:0] ton_cycles = 10'd10;
  logic out_low = 1'b0;
  logic valley_over = 1'b0;
  logic zero_cross = 1'b0;
  logic neg_limit = 1'b0;
  logic pump_ok = 1'b1;
  logic force_dis = 1'b0;
  logic hs_en;
  logic ls_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  cot_phase_seq #(
    .CNT_W(T_CNT_W), .MIN_ON(T_MIN_ON), .MIN_OFF(T_MIN_OFF),
    .DEAD(T_DEAD), .IDLE_CYC(T_IDLE)
  ) u_cot_phase_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_sel(mode_sel),
    .ton_cycles(ton_cycles), .out_low(out_low), .valley_over(valley_over),
    .zero_cross(zero_cross), .neg_limit(neg_limit), .pump_ok(pump_ok),
    .force_dis(force_dis), .hs_en(hs_en), .ls_en(ls_en)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_on(input int t);
    return (t < T_MIN_ON) ? T_MIN_ON : t;
  endfunction

  // monitor: samples at the falling edge; inputs change 1 time unit later
  int cyc = 0;
  logic smp_hs = 1'b0;
  logic smp_ls = 1'b0;
  bit mon_on = 1'b0;
  int hs_rise_at = -1000;
  int hs_fall_at = -1000;
  int ls_fall_at = -1000;
  int run_exp = 0;
  bit h_ok [16];

  always @(negedge clk) begin
    logic hs;
    logic ls;
    int idx;
    hs = hs_en;
    ls = ls_en;
    cyc++;
    h_ok[cyc % 16] = out_low && !valley_over && !force_dis && en;
    if (mon_on) begin
      chk(!(hs && ls), "R3", int'(hs) + int'(ls), 1);
      if (neg_limit) chk(!ls, "R9", int'(ls), 0);
      if (hs && !smp_hs) begin
        chk(cyc - hs_fall_at >= T_MIN_OFF + T_DEAD, "R12", cyc - hs_fall_at, T_MIN_OFF + T_DEAD);
        chk(cyc - ls_fall_at >= T_DEAD, "R2", cyc - ls_fall_at, T_DEAD);
        idx = (cyc - T_DEAD) % 16;
        chk(h_ok[idx], "R1", int'(h_ok[idx]), 1);
        run_exp = eff_on(int'(ton_cycles));
        hs_rise_at = cyc;
      end
      if (!hs && smp_hs) begin
        if (en) chk(cyc - hs_rise_at == run_exp, "R4", cyc - hs_rise_at, run_exp);
        hs_fall_at = cyc;
      end
      if (ls && !smp_ls) chk(cyc - hs_fall_at >= T_DEAD, "R2", cyc - hs_fall_at, T_DEAD);
      if (!ls && smp_ls) ls_fall_at = cyc;
    end
    smp_hs = hs;
    smp_ls = ls;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_hs(input string req);
    int n;
    n = 0;
    while (!smp_hs && n < 400) begin
      step();
      n++;
    end
    chk(smp_hs, req, int'(smp_hs), 1);
  endtask

  // quiet timeout run, used for R7 and R8
  task automatic quiet_run(input string req);
    int t0;
    int lows;
    out_low = 1'b1;
    zero_cross = 1'b0;
    wait_hs(req);
    t0 = cyc;
    out_low = 1'b0;
    zero_cross = 1'b1;
    while (cyc < t0 + T_IDLE - 1) step();
    chk(!smp_ls, req, int'(smp_ls), 0);
    step();
    chk(smp_ls, req, int'(smp_ls), 1);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!smp_ls) lows++;
    end
    chk(lows == 0, req, lows, 0);
  endtask

  initial begin
    int seen;
    int lows;
    void'($urandom(32'h1c0f_5eed));
    repeat (3) step();
    chk(!smp_hs && !smp_ls, "R10", int'(smp_hs) + int'(smp_ls), 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk(!smp_hs && !smp_ls, "R10", int'(smp_hs) + int'(smp_ls), 0);
    mon_on = 1'b1;

    // R1: valley over limit blocks the start, release gives exact latency
    en = 1'b1; out_low = 1'b1; valley_over = 1'b1;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (smp_hs) seen++;
    end
    chk(seen == 0, "R1", seen, 0);
    valley_over = 1'b0;
    seen = 0;
    for (int i = 0; i < T_DEAD; i++) begin
      step();
      if (smp_hs) seen++;
    end
    chk(seen == 0, "R1", seen, 0);
    step();
    chk(smp_hs, "R1", int'(smp_hs), 1);

    // R4: short, zero and long on-time requests (monitor checks lengths)
    ton_cycles = 10'd0;
    repeat (40) step();
    ton_cycles = 10'd3;
    repeat (40) step();
    ton_cycles = 10'd17;
    repeat (60) step();

    // R6: forced PWM ignores zero crossing
    while (smp_hs) step();
    wait_hs("R6");
    out_low = 1'b0; zero_cross = 1'b1;
    repeat (40) step();
    chk(smp_ls && !smp_hs, "R6", int'(smp_ls), 1);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!smp_ls) lows++;
    end
    chk(lows == 0, "R6", lows, 0);

    // R5: pulse skip opens the low side at zero crossing
    mode_sel = 2'd1; zero_cross = 1'b0; out_low = 1'b1;
    while (smp_hs) step();
    wait_hs("R5");
    out_low = 1'b0;
    while (!smp_ls) step();
    zero_cross = 1'b1;
    step();
    chk(!smp_ls, "R5", int'(smp_ls), 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (smp_ls || smp_hs) seen++;
    end
    chk(seen == 0, "R5", seen, 0);

    // R7: quiet mode timeout
    mode_sel = 2'd2;
    quiet_run("R7");
    // R8: pump flag low turns pulse skip into quiet mode
    out_low = 1'b1;
    while (!smp_hs) step();
    while (smp_hs) step();
    mode_sel = 2'd1; pump_ok = 1'b0;
    out_low = 1'b0; zero_cross = 1'b1;
    repeat (T_IDLE + 20) step();
    quiet_run("R8");
    pump_ok = 1'b1;

    // R10: disable mid on-time
    mode_sel = 2'd0; zero_cross = 1'b0; out_low = 1'b1;
    while (smp_hs) step();
    wait_hs("R10");
    en = 1'b0;
    step();
    chk(!smp_hs && !smp_ls, "R10", int'(smp_hs) + int'(smp_ls), 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (smp_hs || smp_ls) seen++;
    end
    chk(seen == 0, "R10", seen, 0);
    en = 1'b1; out_low = 1'b0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (smp_hs) seen++;
    end
    chk(seen == 0, "R1", seen, 0);

    // R11 and R9: forced discharge and negative limit
    mode_sel = 2'd1; force_dis = 1'b1; out_low = 1'b1; zero_cross = 1'b1;
    repeat (10) step();
    chk(smp_ls, "R11", int'(smp_ls), 1);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (smp_hs || !smp_ls) seen++;
    end
    chk(seen == 0, "R11", seen, 0);
    neg_limit = 1'b1;
    step();
    chk(!smp_ls, "R9", int'(smp_ls), 0);
    neg_limit = 1'b0;
    step();
    chk(smp_ls, "R11", int'(smp_ls), 1);
    force_dis = 1'b0;

    // randomized phase, checked by the monitor (R1 R2 R3 R4 R9 R12)
    for (int i = 0; i < 5000; i++) begin
      if (i % 300 == 0) mode_sel = 2'($urandom_range(0, 3));
      out_low     = ($urandom_range(0, 9) < 4);
      valley_over = ($urandom_range(0, 9) == 0);
      zero_cross  = ($urandom_range(0, 9) < 3);
      neg_limit   = ($urandom_range(0, 19) == 0);
      pump_ok     = ($urandom_range(0, 9) != 0);
      force_dis   = ($urandom_range(0, 49) == 0);
      en          = ($urandom_range(0, 99) != 0);
      ton_cycles  = 10'($urandom_range(0, 20));
      step();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule